// File: doc/BRIEF.md
# Tribit Channel-Symbol Scrambler

This block whitens a stream of 3-bit channel symbols in the transmit path of a serial-tone HF modem. It holds a 12-bit linear feedback shift register in Galois form, with polynomial x^12 + x^6 + x^4 + x + 1, loaded with the seed 0xBAD. For every accepted symbol the register takes eight shift steps in a single clock. The three low bits of the result are added modulo 8 to the incoming tribit.

Each symbol carries a probe flag. When the flag is set, the data tribit is replaced by zero, so the output is the bare scrambling value, which is what a known-probe interval needs. After every 160 accepted symbols the register returns to its seed, so the scrambling sequence has a period of 160 symbols.

Symbols enter and leave through valid/ready handshakes. A single output register lets the block take one symbol per clock when the consumer is always ready.

Top module: `tribit_scrambler`

## Requirements
- R1: After synchronous reset `outValid` is 0 and `inReady` is 1. The first accepted symbol is scrambled with bits [2:0] of the seed 0xBAD after eight Galois steps.
- R2: One Galois step moves every register bit up one position. The old bit 11 becomes the new bit 0 and is also XORed into new bits 1, 4 and 6 (polynomial x^12+x^6+x^4+x+1). Each accepted symbol advances the register by exactly eight such steps.
- R3: With `inProbe`=0, `outData` = (`inData` + tribit) mod 8, where the tribit is bits [2:0] of the register after the eight steps for that symbol.
- R4: With `inProbe`=1, `inData` is ignored and `outData` equals the tribit.
- R5: After the 160th accepted symbol since reset or since the last reseed, the register is reloaded with 0xBAD. The output for symbol k+160 therefore equals the output for symbol k, given the same data and probe inputs.
- R6: While `outValid`=1 and `outReady`=0, `outData` and `outValid` hold their values and `inReady` is 0.
- R7: Cycles without an accepted input (`inValid`=0 or `inReady`=0) leave the register and the symbol count unchanged.
- R8: While `outReady` is held at 1, `inReady` stays 1, so one symbol is accepted and delivered every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input symbol valid |
| inReady | output | 1 | Block can accept an input symbol |
| inData | input | 3 | Input data tribit |
| inProbe | input | 1 | Probe flag: force the data tribit to zero |
| outValid | output | 1 | Scrambled symbol valid |
| outReady | input | 1 | Consumer accepts the scrambled symbol |
| outData | output | 3 | Scrambled tribit |

## Verification
The first input pattern is 320 probe symbols at full rate. It exposes the bare generator sequence, which is compared against a bit-serial model written per tap, and it shows whether symbol k+160 repeats symbol k. A run of all-ones data tells a modulo-8 add apart from an XOR or a wider sum. Bursts separated by idle gaps show whether the register advances on anything other than an accepted symbol. A long random mix of valid, ready, probe and data stresses the backpressure hold, and it crosses the 160-symbol reseed boundary several times at random phases.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int LFSR_W_DEF = 12;
  localparam int SYM_W_DEF  = 3;

  typedef struct packed {
    logic accept;
    logic reseed;
  } scrStrobe_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int PERIOD = 160
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output scrStrobe_t strb
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] symCount;
  logic             atLast;

  assign inReady     = !outValid || outReady;
  assign strb.accept = inValid && inReady;
  assign atLast      = (symCount == LAST);
  assign strb.reseed = strb.accept && atLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      symCount <= '0;
      outValid <= 1'b0;
    end else begin
      if (strb.accept) begin
        symCount <= atLast ? '0 : symCount + 1'b1;
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
    symCount <= LAST);
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.accept && atLast) |=> symCount == '0);
  p_count_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.accept |=> $stable(symCount));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);
  p_full_rate_r8: assert property (@(posedge clk) disable iff (rst)
    outReady |-> inReady);
  p_deliver_r8: assert property (@(posedge clk) disable iff (rst)
    strb.accept |=> outValid);
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int              LFSR_W = LFSR_W_DEF,
  parameter int              SYM_W  = SYM_W_DEF,
  parameter int              STEPS  = 8,
  parameter logic [LFSR_W-1:0] SEED = 12'hBAD,
  parameter logic [LFSR_W-1:0] TAPS = 12'h053
) (
  input  logic             clk,
  input  logic             rst,
  input  scrStrobe_t       strb,
  input  logic [SYM_W-1:0] inData,
  input  logic             inProbe,
  input  logic             outValid,
  input  logic             outReady,
  output logic [SYM_W-1:0] outData
);
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] stage [0:STEPS];
  logic [SYM_W-1:0]  tribit;
  logic [SYM_W-1:0]  dataEff;

  assign stage[0] = lfsr;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    assign stage[s+1] = {stage[s][LFSR_W-2:0], 1'b0}
                      ^ ({LFSR_W{stage[s][LFSR_W-1]}} & TAPS);
  end

  assign tribit  = stage[STEPS][SYM_W-1:0];
  assign dataEff = inProbe ? '0 : inData;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr    <= SEED;
      outData <= '0;
    end else if (strb.accept) begin
      lfsr    <= strb.reseed ? SEED : stage[STEPS];
      outData <= dataEff + tribit;
    end
  end

  p_reseed_r5: assert property (@(posedge clk) disable iff (rst)
    strb.reseed |=> lfsr == SEED);
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.accept |=> $stable(lfsr));
  p_probe_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.accept && inProbe) |=> outData == $past(tribit));
  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outData));
endmodule

// File: rtl/tribit_scrambler.sv
module tribit_scrambler
  import scr_pkg::*;
#(
  parameter int                LFSR_W = LFSR_W_DEF,
  parameter int                SYM_W  = SYM_W_DEF,
  parameter int                STEPS  = 8,
  parameter int                PERIOD = 160,
  parameter logic [LFSR_W-1:0] SEED   = 12'hBAD,
  parameter logic [LFSR_W-1:0] TAPS   = 12'h053
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [SYM_W-1:0] inData,
  input  logic             inProbe,
  output logic             outValid,
  input  logic             outReady,
  output logic [SYM_W-1:0] outData
);
  scrStrobe_t strb;

  scr_ctrl #(.PERIOD(PERIOD)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  scr_datapath #(
    .LFSR_W (LFSR_W),
    .SYM_W  (SYM_W),
    .STEPS  (STEPS),
    .SEED   (SEED),
    .TAPS   (TAPS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inData   (inData),
    .inProbe  (inProbe),
    .outValid (outValid),
    .outReady (outReady),
    .outData  (outData)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

// File: tb/tribit_scrambler_bench.sv
module tribit_scrambler_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [2:0] inData = '0;
  logic       inProbe = 1'b0;
  logic       outReady = 1'b0;
  logic       inReady;
  logic       outValid;
  logic [2:0] outData;

  always #(CLK_PERIOD/2) clk = ~clk;

  tribit_scrambler u_tribit_scrambler (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inProbe(inProbe), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  int errors = 0;
  int checks = 0;
  logic [11:0] refReg;
  int refCount;
  logic [2:0] expQ[$];
  string tagQ[$];
  logic [2:0] record[$];
  bit recording = 0;
  bit checkRate = 0;
  bit stalled = 0;
  logic [2:0] stallData;
  bit done = 0;

  function automatic logic [11:0] refShift(input logic [11:0] r);
    logic [11:0] n;
    logic fb;
    fb = r[11];
    n[0] = fb;
    n[1] = r[0] ^ fb;
    n[2] = r[1];
    n[3] = r[2];
    n[4] = r[3] ^ fb;
    n[5] = r[4];
    n[6] = r[5] ^ fb;
    n[11:7] = r[10:6];
    return n;
  endfunction

  function automatic logic [2:0] addMod8(input logic [2:0] a, input logic [2:0] b);
    int s;
    s = (int'(a) + int'(b)) % 8;
    return s[2:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic refSymbol(input logic [2:0] d, input logic p, output logic [2:0] e);
    for (int i = 0; i < 8; i++) refReg = refShift(refReg);
    e = addMod8(p ? 3'd0 : d, refReg[2:0]);
    refCount++;
    if (refCount == 160) begin
      refCount = 0;
      refReg = 12'hBAD;
    end
  endtask

  task automatic cycle(input logic v, input logic [2:0] d, input logic p,
                       input logic ordy, input string tag);
    logic [2:0] e;
    @(negedge clk);
    inValid = v; inData = d; inProbe = p; outReady = ordy;
    #1;
    if (stalled) begin
      check("R6 valid held", int'(outValid), 1);
      check("R6 data held", int'(outData), int'(stallData));
    end
    if (checkRate) check("R8 inReady", int'(inReady), 1);
    if (outValid && outReady) begin
      if (expQ.size() == 0) check("R3 unexpected output", 1, 0);
      else begin
        e = expQ.pop_front();
        check(tagQ.pop_front(), int'(outData), int'(e));
        if (recording) record.push_back(outData);
      end
    end
    stalled = outValid && !outReady;
    stallData = outData;
    if (inValid && inReady) begin
      refSymbol(d, p, e);
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; inValid = 0; outReady = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    refReg = 12'hBAD;
    refCount = 0;
    expQ.delete();
    tagQ.delete();
    stalled = 0;
    #1;
    check("R1 outValid after reset", int'(outValid), 0);
    check("R1 inReady after reset", int'(inReady), 1);
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || outValid) && guard < 100) begin
      cycle(1'b0, 3'd0, 1'b0, 1'b1, "drain");
      guard++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    doReset();

    // R1 first symbol, R4 probe sequence, R8 full rate, R5 period
    recording = 1;
    cycle(1'b1, 3'd5, 1'b1, 1'b1, "R1 first symbol");
    checkRate = 1;
    for (int k = 1; k < 320; k++) cycle(1'b1, 3'($urandom), 1'b1, 1'b1, "R2 R4 probe");
    drain();
    checkRate = 0;
    recording = 0;
    check("R5 record length", record.size(), 320);
    if (record.size() == 320)
      for (int k = 0; k < 160; k++)
        check("R5 repeat after 160", int'(record[k+160]), int'(record[k]));

    // R3 wrap: all-ones data
    for (int k = 0; k < 20; k++) cycle(1'b1, 3'd7, 1'b0, 1'b1, "R3 data 7");
    drain();

    // R7 idle gaps do not advance
    for (int k = 0; k < 10; k++) begin
      cycle(1'b1, 3'(k), 1'b0, 1'b1, "R7 after gap");
      for (int g = 0; g < 4; g++) cycle(1'b0, 3'd3, 1'b1, 1'b1, "R7 idle");
    end
    drain();

    // R6 long stall
    cycle(1'b1, 3'd2, 1'b0, 1'b0, "R6 stalled symbol");
    for (int g = 0; g < 6; g++) cycle(1'b1, 3'd6, 1'b0, 1'b0, "R6 blocked");
    drain();

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic p;
      p = ($urandom % 4) == 0;
      cycle(($urandom % 4) != 0, 3'($urandom), p, ($urandom % 3) != 0,
            p ? "R4 random probe" : "R2 R3 random data");
    end
    drain();

    // reset mid-stream restarts from seed
    doReset();
    cycle(1'b1, 3'd0, 1'b1, 1'b1, "R1 after second reset");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule